// File: doc/BRIEF.md
# Line-Time Clock Interrupt Unit

This block turns the system clock into a slow periodic tick at either 50 or 60 ticks per second. Each tick sets a completion flag in a one-register control/status word. If interrupts are enabled, the tick also raises a level interrupt request. Software reads the register to see the flag and the enable bit. It writes the register to turn interrupts on or off and to acknowledge a tick by clearing the flag.

The tick period comes from a down-counter. Its two reload values are derived from the `CLK_HZ` parameter, one for each rate. A separate configuration write picks the rate. The unit accepts only the values 50 and 60 and leaves the current rate in place for any other value. A new rate takes effect when the counter next reloads, so the period already under way completes at the old rate.

Top module: `line_clock`

## Requirements
- R1: After reset, the register reads 0x0080: the flag is set, interrupts are disabled and `irq_o` is low. The rate after reset is 60 ticks per second.
- R2: A read returns the flag in bit 7 and the interrupt enable in bit 6. All other bits read as zero.
- R3: A register write with `csr_be_i[0]` set copies data bit 6 into the enable. Data bit 7 = 0 clears the flag; data bit 7 = 1 leaves the flag as it was. A write never sets the flag.
- R4: After a register write, `irq_o` is low unless both the enable and the flag are set. A write never raises `irq_o`, even one that sets the enable while the flag is already set.
- R5: A register write with `csr_be_i` = 2'b10 (high byte lane only) changes nothing.
- R6: Each tick sets the flag and raises `irq_o` if the enable is set. When a tick and a write fall in the same cycle, the tick takes effect after the write.
- R7: `tick_o` pulses for one cycle. The pulses are CLK_HZ/60 cycles apart at rate 60 and CLK_HZ/50 cycles apart at rate 50. The first pulse comes CLK_HZ/60-1 cycles after reset is released.
- R8: A configuration write with `cfg_rate_i` equal to 50 or 60 selects that rate. Any other value is ignored.
- R9: A rate change takes effect at the next counter reload. The tick interval in progress when the write arrives keeps the old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_be_i | input | 2 | Byte lane enables; bit 0 = even (low) byte |
| csr_wdata_i | input | 16 | Register write data |
| csr_rdata_o | output | 16 | Register read data |
| cfg_we_i | input | 1 | Rate configuration write strobe |
| cfg_rate_i | input | 7 | Requested rate in ticks per second |
| tick_o | output | 1 | One-cycle tick pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong divider count shows up as a `tick_o` pulse that comes early or late. The error appears in the first interval after reset or after a rate change, so the per-cycle comparison catches it within one period. A wrong flag or enable shows on `csr_rdata_o` in the cycle right after the write or tick that produced it. A request that is raised or dropped in error is visible on `irq_o` on the same edge. The cases that most need probing are a write that lands on the same edge as a tick, and a rate write that lands on a reload edge.

// File: rtl/line_clock_pkg.sv
package line_clock_pkg;
  localparam int unsigned DONE_BIT = 7;
  localparam int unsigned IE_BIT   = 6;
  localparam logic [6:0]  RATE_50  = 7'd50;
  localparam logic [6:0]  RATE_60  = 7'd60;

  typedef enum logic {
    RATE_SEL_60 = 1'b0,
    RATE_SEL_50 = 1'b1
  } rate_sel_e;
endpackage

// File: rtl/lc_rate_reg.sv
module lc_rate_reg
  import line_clock_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [6:0] cfg_rate_i,
  output rate_sel_e  sel_o
);
  rate_sel_e sel_q;
  logic      is_50, is_60;

  assign is_50 = (cfg_rate_i == RATE_50);
  assign is_60 = (cfg_rate_i == RATE_60);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 sel_q <= RATE_SEL_60;
    else if (cfg_we_i && is_50)  sel_q <= RATE_SEL_50;
    else if (cfg_we_i && is_60)  sel_q <= RATE_SEL_60;
  end

  assign sel_o = sel_q;

  assert_bad_rate_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !is_50 && !is_60) |=> $stable(sel_q));
  assert_rate_taken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && is_50) |=> (sel_q == RATE_SEL_50));
endmodule

// File: rtl/lc_divider.sv
module lc_divider
  import line_clock_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  rate_sel_e sel_i,
  output logic      tick_o
);
  localparam int unsigned DIV_60 = CLK_HZ / 60;
  localparam int unsigned DIV_50 = CLK_HZ / 50;
  localparam int unsigned CNT_W  = $clog2(DIV_50);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  // reload value chosen from the rate held at the reload edge
  assign reload = (sel_i == RATE_SEL_50) ? CNT_W'(DIV_50 - 1) : CNT_W'(DIV_60 - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(DIV_60 - 1);
    else if (cnt_q == '0)  cnt_q <= reload;
    else                   cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  assert_cnt_in_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DIV_50 - 1));
  assert_tick_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lc_csr.sv
module lc_csr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wr_i,
  input  logic wr_done_i,
  input  logic wr_ie_i,
  output logic done_o,
  output logic ie_o,
  output logic irq_o
);
  logic done_q, ie_q, irq_q;
  logic done_n, ie_n, irq_n;

  always_comb begin
    done_n = done_q;
    ie_n   = ie_q;
    irq_n  = irq_q;
    if (wr_i) begin
      ie_n = wr_ie_i;
      if (!wr_done_i) done_n = 1'b0;
      if (!(ie_n && done_n)) irq_n = 1'b0;
    end
    // tick applies after a same-cycle write
    if (tick_i) begin
      done_n = 1'b1;
      if (ie_n) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b1;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      ie_q   <= ie_n;
      irq_q  <= irq_n;
    end
  end

  assign done_o = done_q;
  assign ie_o   = ie_q;
  assign irq_o  = irq_q;

  assert_irq_needs_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (ie_q && done_q));
  assert_write_no_raise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tick_i) |=> !$rose(irq_q));
  assert_write_no_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !tick_i) |=> !$rose(done_q));
  assert_tick_sets_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> done_q);
  assert_tick_raises_irq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ie_q && !wr_i) |=> irq_q);
endmodule

// File: rtl/line_clock.sv
module line_clock
  import line_clock_pkg::*;
#(
  parameter int unsigned CLK_HZ = 3000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_we_i,
  input  logic [1:0]  csr_be_i,
  input  logic [15:0] csr_wdata_i,
  output logic [15:0] csr_rdata_o,
  input  logic        cfg_we_i,
  input  logic [6:0]  cfg_rate_i,
  output logic        tick_o,
  output logic        irq_o
);
  rate_sel_e sel;
  logic      tick, done, ie, wr;
  logic      unused_wdata;

  // only the even byte lane carries implemented bits
  assign wr           = csr_we_i && csr_be_i[0];
  assign unused_wdata = ^{csr_wdata_i[15:8], csr_wdata_i[5:0], csr_be_i[1]};

  lc_rate_reg u_rate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_rate_i (cfg_rate_i),
    .sel_o      (sel)
  );

  lc_divider #(.CLK_HZ(CLK_HZ)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .tick_o (tick)
  );

  lc_csr u_csr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_i      (wr),
    .wr_done_i (csr_wdata_i[DONE_BIT]),
    .wr_ie_i   (csr_wdata_i[IE_BIT]),
    .done_o    (done),
    .ie_o      (ie),
    .irq_o     (irq_o)
  );

  always_comb begin
    csr_rdata_o           = '0;
    csr_rdata_o[DONE_BIT] = done;
    csr_rdata_o[IE_BIT]   = ie;
  end

  assign tick_o = tick;

  assert_odd_byte_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && !csr_be_i[0] && !tick) |=> $stable(csr_rdata_o));
endmodule

// File: tb/line_clock_test.sv
module line_clock_test;
  localparam int CLK_PERIOD = 10;
  localparam int HZ   = 3000;
  localparam int D60  = HZ / 60;
  localparam int D50  = HZ / 50;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_be = 2'b00;
  logic [15:0] csr_wdata = '0;
  logic [15:0] csr_rdata;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_rate = '0;
  logic        tick, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done_run = 0;

  // behavioural reference state
  int m_cnt, m_rate;
  bit m_done, m_ie, m_irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_clock #(.CLK_HZ(HZ)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_we_i(csr_we), .csr_be_i(csr_be), .csr_wdata_i(csr_wdata),
    .csr_rdata_o(csr_rdata),
    .cfg_we_i(cfg_we), .cfg_rate_i(cfg_rate),
    .tick_o(tick), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = D60 - 1; m_rate = 60;
      m_done = 1; m_ie = 0; m_irq = 0;
    end else begin
      bit t;
      t = (m_cnt == 0);
      if (t) m_cnt = ((m_rate == 50) ? D50 : D60) - 1;
      else   m_cnt = m_cnt - 1;
      if (cfg_we && (cfg_rate == 7'd50 || cfg_rate == 7'd60)) m_rate = int'(cfg_rate);
      if (csr_we && csr_be[0]) begin
        m_ie = csr_wdata[6];
        if (!csr_wdata[7]) m_done = 0;
        if (!(m_ie && m_done)) m_irq = 0;
      end
      if (t) begin
        m_done = 1;
        if (m_ie) m_irq = 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done_run) begin
      check("R1 R2 R3 R5 rdata", 32'(csr_rdata), 32'({8'h00, m_done, m_ie, 6'b0}));
      check("R4 R6 irq", 32'(irq), 32'(m_irq));
      check("R7 R8 R9 tick", 32'(tick), 32'(m_cnt == 0));
    end
  end

  task automatic wr_csr(input logic [1:0] be, input logic [15:0] d);
    csr_we = 1'b1; csr_be = be; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0; csr_be = 2'b00; csr_wdata = '0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic next_tick(input bit do_cfg, input logic [6:0] v, output int n);
    if (do_cfg) begin cfg_we = 1'b1; cfg_rate = v; end
    n = 0;
    do begin
      @(negedge clk);
      cfg_we = 1'b0;
      n++;
    end while (!tick);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset rdata", 32'(csr_rdata), 32'h0080);
    check("R1 reset irq", 32'(irq), 0);
    // first tick position after reset
    n = 0;
    while (!tick) begin @(negedge clk); n++; end
    check("R7 first tick", n, D60 - 1);
    @(negedge clk);
    // enable with flag set: no request
    wr_csr(2'b11, 16'hFFFF);
    check("R2 R3 read bits", 32'(csr_rdata), 32'h00C0);
    check("R4 no raise", 32'(irq), 0);
    wait_tick(); @(negedge clk);
    check("R6 tick irq", 32'(irq), 1);
    wr_csr(2'b10, 16'h0000);
    check("R5 odd byte rdata", 32'(csr_rdata), 32'h00C0);
    check("R5 odd byte irq", 32'(irq), 1);
    wr_csr(2'b01, 16'h0040);
    check("R3 clear done", 32'(csr_rdata), 32'h0040);
    check("R4 irq dropped", 32'(irq), 0);
    wr_csr(2'b01, 16'h00C0);
    check("R3 done not set", 32'(csr_rdata), 32'h0040);
    check("R4 still low", 32'(irq), 0);
    wr_csr(2'b01, 16'h0000);
    wait_tick(); @(negedge clk);
    check("R6 tick no ie rdata", 32'(csr_rdata), 32'h0080);
    check("R6 tick no ie irq", 32'(irq), 0);
    // write coincident with tick
    wait_tick();
    wr_csr(2'b01, 16'h0040);
    check("R6 coincident rdata", 32'(csr_rdata), 32'h00C0);
    check("R6 coincident irq", 32'(irq), 1);
    // periods and rate selection
    wait_tick();
    next_tick(1'b0, 7'd0, n);  check("R7 period 60", n, D60);
    next_tick(1'b1, 7'd77, n); check("R8 bad rate", n, D60);
    next_tick(1'b0, 7'd0, n);  check("R8 bad rate kept", n, D60);
    next_tick(1'b1, 7'd50, n); check("R9 old period", n, D60);
    next_tick(1'b0, 7'd0, n);  check("R7 period 50", n, D50);
    next_tick(1'b1, 7'd60, n); check("R9 old period 50", n, D50);
    next_tick(1'b0, 7'd0, n);  check("R8 back to 60", n, D60);
    done_run = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog: actual hung expected finish");
    done_run = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule